// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the clock and data lines of a two-wire I2C bus without ever driving them and turns what it sees into a stream of tagged events. The events are start, repeated start, stop, address byte, data byte, ACK and NACK. Each event is a one-cycle strobe that carries a kind code, a byte value and a direction flag. Both lines pass through a synchronizer and a majority glitch filter before any edge is looked at. Short spikes therefore do not create bus conditions.

Each transfer is measured from its most recent start to its stop. At the stop the block reports the elapsed system clock cycles and the number of bits that were acknowledged in that span. Software or a downstream block can derive a bitrate from the two numbers.

A configuration input chooses how an address is presented. It can be the 7-bit address with the direction bit removed, or the raw byte as it appeared on the wire.

Top module: `i2c_watch`

## Requirements
- R1: SDA falling while SCL is high, when no transfer is open, produces an event of kind 0 (start) with byte 0 and direction 0.
- R2: A start condition while a transfer is open (after a start and before any stop) produces kind 1 (repeated start). A stop closes the transfer, so the next start is kind 0 again.
- R3: SDA rising while SCL is high inside an open transfer produces kind 2 (stop). A stop condition while no transfer is open produces no event.
- R4: Bits are sampled on SCL rising edges, most significant bit first. The first complete byte after a start or repeated start is the address. Its bit 0 gives the direction (1 read, 0 write), and it is reported as kind 6 for a read or kind 7 for a write, with the direction on the read flag.
- R5: With `addr_raw` low the address event carries the byte shifted right by one, so bit 7 is zero. With `addr_raw` high it carries the unshifted 8-bit byte.
- R6: The SCL rising edge after every complete byte samples the acknowledge: SDA low gives kind 3 (ACK) and SDA high gives kind 4 (NACK). The read flag of this event carries the transfer direction.
- R7: Every byte after an acknowledge is a data byte of kind 8 (read) or kind 9 (write). It takes the direction of the latest address, and any number of data bytes may follow in a row.
- R8: `xfer_valid` pulses in the same cycle as each stop event. `xfer_cycles` equals the number of system clock cycles between the detection of the latest start or repeated start and the detection of the stop. `xfer_bits` equals 9 for every acknowledged byte since that start. Both counts saturate.
- R9: After reset, no event of any kind is produced until a start condition has been seen, whatever SCL and SDA do.
- R10: A start or stop condition that arrives after two or more bits of a byte have been sampled discards that byte. No byte event is produced for it, and `trunc_flag` pulses together with the start, repeated start or stop event.
- R11: A level lasting a single system clock cycle on either line is rejected by the filter and causes no event.
- R12: `evt_valid` is a single-cycle strobe, and `evt_kind`, `evt_byte` and `evt_read` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_raw | input | 1 | Bus clock line, unsynchronized |
| sda_raw | input | 1 | Bus data line, unsynchronized |
| addr_raw | input | 1 | 1: report address byte unshifted; 0: report 7-bit address |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_kind | output | 4 | Event kind code (0,1,2,3,4,6,7,8,9) |
| evt_byte | output | 8 | Address or data value, 0 for conditions and acknowledges |
| evt_read | output | 1 | Direction: 1 read, 0 write |
| trunc_flag | output | 1 | Pulses with a condition event that cut a byte short |
| xfer_valid | output | 1 | One-cycle strobe with the transfer measurement |
| xfer_cycles | output | CYC_W | Clock cycles from latest start to stop |
| xfer_bits | output | BITS_W | Acknowledged bits from latest start to stop |

## Verification
The bench sweeps every 8-bit address value. It alternates the address format, varies the data ACK or NACK, and inserts a repeated start into every eighth transfer, which catches a design that forgets to reset the bit and cycle counts at a repeated start or that mixes up the two address forms. Separate cases drive a stop with no open transfer, line activity before any start, and one-cycle spikes on each line. A design that lacked idle gating or filtering would emit spurious conditions in those cases. The truncation cases put a condition in the middle of an address byte and in the middle of a data byte. A decoder that counted the condition's own SCL rise as a lost bit would flag every normal stop, and one that ignored conditions mid-byte would emit a bogus byte.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int BYTE_W = 8;
   localparam int BCNT_W = $clog2(BYTE_W);

   typedef enum logic [3:0] {
      EV_START   = 4'd0,
      EV_RSTART  = 4'd1,
      EV_STOP    = 4'd2,
      EV_ACK     = 4'd3,
      EV_NACK    = 4'd4,
      EV_ADDR_RD = 4'd6,
      EV_ADDR_WR = 4'd7,
      EV_DATA_RD = 4'd8,
      EV_DATA_WR = 4'd9
   } ev_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_DATA
   } mon_state_t;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic sda;
   } line_cond_t;
endpackage

// File: rtl/i2c_watch_filt.sv
module i2c_watch_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int HALF  = FILT_TAPS / 2;
   localparam int CNT_W = $clog2(FILT_TAPS + 1);

   logic [SYNC_STAGES-1:0] sy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC_STAGES-2:0], raw};
   end

   generate
      if (FILT_TAPS == 1) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean <= 1'b1;
            else        clean <= sy[SYNC_STAGES-1];
         end
      end else begin : g_major
         logic [FILT_TAPS-1:0] win;
         logic [CNT_W-1:0]     ones;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) win <= '1;
            else        win <= {win[FILT_TAPS-2:0], sy[SYNC_STAGES-1]};
         end

         always_comb begin
            ones = '0;
            for (int i = 0; i < FILT_TAPS; i++) ones = ones + CNT_W'(win[i]);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean <= 1'b1;
            else        clean <= (ones > CNT_W'(HALF));
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_watch_cond.sv
module i2c_watch_cond
   import i2c_watch_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_f,
   input  logic       sda_f,
   output line_cond_t cond
);
   timeunit 1ns;
   timeprecision 1ps;

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      cond.start = scl_f & scl_q & sda_q & ~sda_f;
      cond.stop  = scl_f & scl_q & ~sda_q & sda_f;
      cond.rise  = scl_f & ~scl_q;
      cond.sda   = sda_f;
   end
endmodule

// File: rtl/i2c_watch_fsm.sv
module i2c_watch_fsm
   import i2c_watch_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  line_cond_t        cond,
   input  logic              addr_raw,
   output logic              evt_valid,
   output ev_kind_t          evt_kind,
   output logic [BYTE_W-1:0] evt_byte,
   output logic              evt_read,
   output logic              trunc,
   output logic              acc_start,
   output logic              acc_stop,
   output logic [BCNT_W:0]   acc_bits
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

   mon_state_t        state;
   logic [BYTE_W-1:0] shreg;
   logic [BCNT_W-1:0] bcnt;
   logic              dir;
   logic              in_rep;
   logic              collecting;
   logic              byte_done;
   logic              ack_take;
   logic              lost_bits;
   logic [BYTE_W-1:0] full;

   always_comb begin
      collecting = (state == ST_ADDR) || (state == ST_DATA);
      acc_start  = cond.start && (state != ST_ACK);
      acc_stop   = cond.stop && collecting;
      byte_done  = cond.rise && collecting && (bcnt == LAST_BIT);
      ack_take   = cond.rise && (state == ST_ACK);
      full       = {shreg[BYTE_W-2:0], cond.sda};
      lost_bits  = collecting && (bcnt > BCNT_W'(1));
      if (byte_done)     acc_bits = (BCNT_W+1)'(BYTE_W);
      else if (ack_take) acc_bits = (BCNT_W+1)'(1);
      else               acc_bits = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bcnt      <= '0;
         dir       <= 1'b0;
         in_rep    <= 1'b0;
         evt_valid <= 1'b0;
         evt_kind  <= EV_START;
         evt_byte  <= '0;
         evt_read  <= 1'b0;
         trunc     <= 1'b0;
      end else begin
         evt_valid <= 1'b0;
         trunc     <= 1'b0;
         if (acc_start) begin
            evt_valid <= 1'b1;
            evt_kind  <= in_rep ? EV_RSTART : EV_START;
            evt_byte  <= '0;
            evt_read  <= 1'b0;
            trunc     <= lost_bits;
            in_rep    <= 1'b1;
            state     <= ST_ADDR;
            bcnt      <= '0;
            dir       <= 1'b0;
         end else if (acc_stop) begin
            evt_valid <= 1'b1;
            evt_kind  <= EV_STOP;
            evt_byte  <= '0;
            evt_read  <= 1'b0;
            trunc     <= lost_bits;
            in_rep    <= 1'b0;
            state     <= ST_IDLE;
            bcnt      <= '0;
            dir       <= 1'b0;
         end else if (cond.rise) begin
            unique case (state)
               ST_ADDR, ST_DATA: begin
                  shreg <= full;
                  bcnt  <= bcnt + 1'b1;
                  if (byte_done) begin
                     evt_valid <= 1'b1;
                     state     <= ST_ACK;
                     bcnt      <= '0;
                     if (state == ST_ADDR) begin
                        dir      <= full[0];
                        evt_kind <= full[0] ? EV_ADDR_RD : EV_ADDR_WR;
                        evt_byte <= addr_raw ? full : {1'b0, full[BYTE_W-1:1]};
                        evt_read <= full[0];
                     end else begin
                        evt_kind <= dir ? EV_DATA_RD : EV_DATA_WR;
                        evt_byte <= full;
                        evt_read <= dir;
                     end
                  end
               end
               ST_ACK: begin
                  evt_valid <= 1'b1;
                  evt_kind  <= cond.sda ? EV_NACK : EV_ACK;
                  evt_byte  <= '0;
                  evt_read  <= dir;
                  state     <= ST_DATA;
                  bcnt      <= '0;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_watch_meter.sv
module i2c_watch_meter #(
   parameter int CYC_W  = 24,
   parameter int BITS_W = 16,
   parameter int ADD_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_start,
   input  logic              acc_stop,
   input  logic [ADD_W-1:0]  acc_bits,
   output logic              xfer_valid,
   output logic [CYC_W-1:0]  xfer_cycles,
   output logic [BITS_W-1:0] xfer_bits
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [CYC_W-1:0]  CYC_MAX = {CYC_W{1'b1}};
   localparam logic [BITS_W-1:0] BIT_MAX = {BITS_W{1'b1}};

   logic              running;
   logic [CYC_W-1:0]  cyc;
   logic [BITS_W-1:0] bits;
   logic [BITS_W:0]   bits_sum;

   assign bits_sum = {1'b0, bits} + (BITS_W+1)'(acc_bits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running     <= 1'b0;
         cyc         <= '0;
         bits        <= '0;
         xfer_valid  <= 1'b0;
         xfer_cycles <= '0;
         xfer_bits   <= '0;
      end else begin
         xfer_valid <= 1'b0;
         if (acc_start) begin
            running <= 1'b1;
            cyc     <= '0;
            bits    <= '0;
         end else if (acc_stop) begin
            running     <= 1'b0;
            xfer_valid  <= 1'b1;
            xfer_cycles <= (cyc == CYC_MAX) ? CYC_MAX : cyc + 1'b1;
            xfer_bits   <= bits;
         end else if (running) begin
            if (cyc != CYC_MAX) cyc <= cyc + 1'b1;
            bits <= bits_sum[BITS_W] ? BIT_MAX : bits_sum[BITS_W-1:0];
         end
      end
   end
endmodule

// File: rtl/i2c_watch.sv
module i2c_watch
   import i2c_watch_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3,
   parameter int CYC_W       = 24,
   parameter int BITS_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_raw,
   input  logic              sda_raw,
   input  logic              addr_raw,
   output logic              evt_valid,
   output logic [3:0]        evt_kind,
   output logic [7:0]        evt_byte,
   output logic              evt_read,
   output logic              trunc_flag,
   output logic              xfer_valid,
   output logic [CYC_W-1:0]  xfer_cycles,
   output logic [BITS_W-1:0] xfer_bits
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LINES = 2;
   localparam int ADD_W = BCNT_W + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((FILT_TAPS < 1) || (FILT_TAPS % 2 == 0)) begin : g_bad_taps
         $error("FILT_TAPS must be odd and positive");
      end
      if (CYC_W < 8 || BITS_W < 8) begin : g_bad_cnt
         $error("measurement counters too narrow");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("byte width must be 8");
      end
   endgenerate

   logic [LINES-1:0] raw_v;
   logic [LINES-1:0] flt_v;
   line_cond_t       cond;
   ev_kind_t         kind_w;
   logic             acc_start;
   logic             acc_stop;
   logic [ADD_W-1:0] acc_bits;

   assign raw_v = {sda_raw, scl_raw};

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         i2c_watch_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_TAPS  (FILT_TAPS)
         ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[g]),
            .clean(flt_v[g])
         );
      end
   endgenerate

   i2c_watch_cond u_cond (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_f(flt_v[0]),
      .sda_f(flt_v[1]),
      .cond (cond)
   );

   i2c_watch_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond     (cond),
      .addr_raw (addr_raw),
      .evt_valid(evt_valid),
      .evt_kind (kind_w),
      .evt_byte (evt_byte),
      .evt_read (evt_read),
      .trunc    (trunc_flag),
      .acc_start(acc_start),
      .acc_stop (acc_stop),
      .acc_bits (acc_bits)
   );

   assign evt_kind = kind_w;

   i2c_watch_meter #(
      .CYC_W (CYC_W),
      .BITS_W(BITS_W),
      .ADD_W (ADD_W)
   ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_start  (acc_start),
      .acc_stop   (acc_stop),
      .acc_bits   (acc_bits),
      .xfer_valid (xfer_valid),
      .xfer_cycles(xfer_cycles),
      .xfer_bits  (xfer_bits)
   );
endmodule

// File: rtl/i2c_watch_chk.sv
module i2c_watch_chk
   import i2c_watch_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       addr_raw,
   input logic       evt_valid,
   input logic [3:0] evt_kind,
   input logic [7:0] evt_byte,
   input logic       evt_read,
   input logic       trunc_flag,
   input logic       xfer_valid
);
   timeunit 1ns;
   timeprecision 1ps;

   logic       in_xfer;
   logic       cur_dir;
   logic [3:0] last_kind;
   logic       is_addr, is_data, is_cond, is_ack;

   assign is_addr = (evt_kind == EV_ADDR_RD) || (evt_kind == EV_ADDR_WR);
   assign is_data = (evt_kind == EV_DATA_RD) || (evt_kind == EV_DATA_WR);
   assign is_ack  = (evt_kind == EV_ACK) || (evt_kind == EV_NACK);
   assign is_cond = (evt_kind == EV_START) || (evt_kind == EV_RSTART) || (evt_kind == EV_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_xfer   <= 1'b0;
         cur_dir   <= 1'b0;
         last_kind <= EV_STOP;
      end else if (evt_valid) begin
         last_kind <= evt_kind;
         if (evt_kind == EV_START || evt_kind == EV_RSTART) in_xfer <= 1'b1;
         if (evt_kind == EV_STOP) in_xfer <= 1'b0;
         if (is_addr) cur_dir <= evt_read;
      end
   end

   p_fresh_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && evt_kind == EV_START |-> !in_xfer);

   p_repeat_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && evt_kind == EV_RSTART |-> in_xfer);

   p_stop_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && evt_kind == EV_STOP |-> in_xfer);

   p_addr_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && is_addr |->
         (last_kind == EV_START || last_kind == EV_RSTART) && (evt_read == (evt_kind == EV_ADDR_RD)));

   p_addr_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && is_addr |->
         ($past(addr_raw) ? (evt_byte[0] == evt_read) : (evt_byte[7] == 1'b0)));

   p_ack_after_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && is_ack |-> (last_kind >= 4'd6) && (evt_read == cur_dir));

   p_data_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && is_data |->
         (evt_read == cur_dir) && (evt_read == (evt_kind == EV_DATA_RD)) && (last_kind == EV_ACK || last_kind == EV_NACK));

   p_meas_at_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> evt_valid && evt_kind == EV_STOP);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !in_xfer |-> evt_kind == EV_START);

   p_trunc_on_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trunc_flag |-> evt_valid && is_cond);

   p_hold_between_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |-> $stable(evt_kind) && $stable(evt_byte) && $stable(evt_read));
endmodule

bind i2c_watch i2c_watch_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_raw  (addr_raw),
   .evt_valid (evt_valid),
   .evt_kind  (evt_kind),
   .evt_byte  (evt_byte),
   .evt_read  (evt_read),
   .trunc_flag(trunc_flag),
   .xfer_valid(xfer_valid)
);

// File: tb/sim_i2c_watch.sv
module sim_i2c_watch;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CYC_W  = 24;
   localparam int BITS_W = 16;
   localparam int H      = 4;
   localparam int MAXEV  = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scl = 1'b1;
   logic              sda = 1'b1;
   logic              addr_raw = 1'b0;
   logic              evt_valid;
   logic [3:0]        evt_kind;
   logic [7:0]        evt_byte;
   logic              evt_read;
   logic              trunc_flag;
   logic              xfer_valid;
   logic [CYC_W-1:0]  xfer_cycles;
   logic [BITS_W-1:0] xfer_bits;

   i2c_watch #(.SYNC_STAGES(2), .FILT_TAPS(3), .CYC_W(CYC_W), .BITS_W(BITS_W)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl), .sda_raw(sda), .addr_raw(addr_raw),
      .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_byte(evt_byte), .evt_read(evt_read),
      .trunc_flag(trunc_flag), .xfer_valid(xfer_valid), .xfer_cycles(xfer_cycles),
      .xfer_bits(xfer_bits)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   int   ev_n = 0;
   int   lg_kind [MAXEV];
   int   lg_byte [MAXEV];
   int   lg_read [MAXEV];
   int   lg_trunc[MAXEV];
   int   xf_n = 0;
   int   xf_cyc = 0;
   int   xf_bits = 0;
   int   dbl = 0;
   int   unstable = 0;
   logic prev_v = 1'b0;
   logic [3:0] pk = '0;
   logic [7:0] pb = '0;

   int   ex_n = 0;
   int   ex_kind[MAXEV];
   int   ex_byte[MAXEV];
   int   ex_read[MAXEV];
   int   ex_trunc[MAXEV];

   time  t_open = 0;
   time  t_close = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (evt_valid) begin
            if (ev_n < MAXEV) begin
               lg_kind[ev_n]  = int'(evt_kind);
               lg_byte[ev_n]  = int'(evt_byte);
               lg_read[ev_n]  = int'(evt_read);
               lg_trunc[ev_n] = int'(trunc_flag);
            end
            ev_n++;
            if (prev_v) dbl++;
         end else if (evt_kind !== pk || evt_byte !== pb) begin
            unstable++;
         end
         if (xfer_valid) begin
            xf_n++;
            xf_cyc  = int'(xfer_cycles);
            xf_bits = int'(xfer_bits);
         end
         prev_v = evt_valid;
         pk = evt_kind;
         pb = evt_byte;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic push(input int k, input int b, input int r, input int t);
      ex_kind[ex_n]  = k;
      ex_byte[ex_n]  = b;
      ex_read[ex_n]  = r;
      ex_trunc[ex_n] = t;
      ex_n++;
   endtask

   task automatic clear_logs();
      ev_n = 0;
      ex_n = 0;
      xf_n = 0;
   endtask

   task automatic bus_start();
      sda = 1'b0; t_open = $time; wt(H);
      scl = 1'b0; wt(H);
   endtask

   task automatic bus_bit(input logic v);
      sda = v; wt(H);
      scl = 1'b1; wt(H);
      scl = 1'b0; wt(H);
   endtask

   task automatic bus_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
   endtask

   task automatic bus_rstart();
      sda = 1'b1; wt(H);
      scl = 1'b1; wt(H);
      sda = 1'b0; t_open = $time; wt(H);
      scl = 1'b0; wt(H);
   endtask

   task automatic bus_stop();
      sda = 1'b0; wt(H);
      scl = 1'b1; wt(H);
      sda = 1'b1; t_close = $time; wt(3 * H);
   endtask

   function automatic string tag_of(input int k);
      case (k)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3, 4: return "R6";
         6, 7: return "R4/R5";
         default: return "R7";
      endcase
   endfunction

   task automatic compare_events(input string where);
      chk({"event count ", where, " R4"}, ev_n, ex_n);
      for (int i = 0; i < ex_n && i < ev_n && i < MAXEV; i++) begin
         chk({"kind ", where, " ", tag_of(ex_kind[i])}, lg_kind[i], ex_kind[i]);
         chk({"byte ", where, " ", tag_of(ex_kind[i])}, lg_byte[i], ex_byte[i]);
         chk({"read ", where, " ", tag_of(ex_kind[i])}, lg_read[i], ex_read[i]);
         chk({"trunc ", where, " R10"}, lg_trunc[i], ex_trunc[i]);
      end
   endtask

   task automatic compare_meas(input string where, input int bits);
      chk({"xfer strobes ", where, " R8"}, xf_n, 1);
      chk({"xfer cycles ", where, " R8"}, xf_cyc, int'((t_close - t_open) / 20));
      chk({"xfer bits ", where, " R8"}, xf_bits, bits);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired R12 act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      wt(5);
      chk("reset evt_valid R12", int'(evt_valid), 0);
      chk("reset xfer_valid R8", int'(xfer_valid), 0);
      chk("reset trunc R10", int'(trunc_flag), 0);
      rst_n = 1'b1;
      wt(10);

      // R9 and R3: clocking and a stop pattern before any start
      clear_logs();
      for (int i = 0; i < 3; i++) begin
         scl = 1'b0; wt(H); sda = ~sda; wt(H); scl = 1'b1; wt(H);
      end
      scl = 1'b0; wt(H); sda = 1'b0; wt(H); scl = 1'b1; wt(H);
      sda = 1'b1; wt(3 * H);
      chk("no events before start R9", ev_n, 0);
      chk("idle stop ignored R3", xf_n, 0);

      // R11: single-cycle spikes on each line while idle
      clear_logs();
      sda = 1'b0; wt(1); sda = 1'b1; wt(3 * H);
      scl = 1'b0; wt(1); scl = 1'b1; wt(3 * H);
      chk("sda spike rejected R11", ev_n, 0);
      chk("scl spike rejected R11", xf_n, 0);

      // R10: start, partial address, repeated start, address, partial data, stop
      clear_logs();
      addr_raw = 1'b0;
      bus_start();               push(0, 0, 0, 0);
      for (int i = 0; i < 5; i++) bus_bit(1'(i & 1));
      bus_rstart();              push(1, 0, 0, 1);
      bus_byte(8'h3C);           push(7, 8'h1E, 0, 0);
      bus_bit(1'b0);             push(3, 0, 0, 0);
      bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
      bus_stop();                push(2, 0, 0, 1);
      compare_events("trunc");
      compare_meas("trunc", 9);

      // R10 negative: start then stop at once, nothing lost
      clear_logs();
      bus_start();               push(0, 0, 0, 0);
      bus_stop();                push(2, 0, 0, 0);
      compare_events("empty");
      compare_meas("empty", 0);

      // Sweep over every address byte
      for (int b = 0; b < 256; b++) begin
         logic [7:0] ab;
         logic [7:0] db;
         logic [7:0] a2;
         int         rd;
         int         bits;
         ab = 8'(b);
         db = ~ab;
         a2 = ab ^ 8'h5A;
         rd = int'(ab[0]);
         clear_logs();
         addr_raw = ab[4];
         bus_start();            push(0, 0, 0, 0);
         bus_byte(ab);           push(rd ? 6 : 7, ab[4] ? int'(ab) : int'(ab >> 1), rd, 0);
         bus_bit(1'b0);          push(3, 0, rd, 0);
         bus_byte(db);           push(rd ? 8 : 9, int'(db), rd, 0);
         bus_bit(ab[1]);         push(ab[1] ? 4 : 3, 0, rd, 0);
         bits = 18;
         if (b % 8 == 7) begin
            bus_byte(ab);        push(rd ? 8 : 9, int'(ab), rd, 0);
            bus_bit(1'b0);       push(3, 0, rd, 0);
            bus_rstart();        push(1, 0, 0, 0);
            bus_byte(a2);        push(a2[0] ? 6 : 7, ab[4] ? int'(a2) : int'(a2 >> 1), int'(a2[0]), 0);
            bus_bit(1'b1);       push(4, 0, int'(a2[0]), 0);
            bits = 9;
         end
         bus_stop();             push(2, 0, 0, 0);
         compare_events("sweep");
         compare_meas("sweep", bits);
      end

      // A fresh start after the sweep must again be kind 0
      clear_logs();
      bus_start();               push(0, 0, 0, 0);
      bus_stop();                push(2, 0, 0, 0);
      compare_events("restart R2");

      chk("single-cycle strobe R12", dbl, 0);
      chk("outputs hold between strobes R12", unstable, 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule